// File: doc/BRIEF.md
# Elastic Register Stage with Selectable Data Policies

This block is a single-slot pipeline register placed between a producer and a consumer that both speak a valid/ready handshake. A word moves across either edge of the stage in any cycle where the sender's valid and the receiver's ready are both high. The stage keeps at most one word. Its upstream ready signal is combinational: it depends on the downstream ready and on whether the slot is occupied. Because of this, a full stage can hand its word downstream and take a new one in the same cycle, which sustains one word per clock.

Two elaboration-time choices shape the data register. `CLEAR_DATA` selects whether the synchronous reset also forces the data register to zero, or whether only the occupancy flag is cleared. `LOAD_MODE` selects when the data register is written. In `LOAD_ON_ACCEPT` (encoding 0) it loads only when an upstream transfer actually happens. In `LOAD_ON_OPEN` (encoding 1) it loads on every cycle the stage reports ready, whether or not the producer is offering a word. The first mode saves switching activity. The second has a shallower load-enable path.

Top module: `elastic_stage`

## Requirements
- R1: A word enters the stage exactly in a cycle where `in_valid` and `in_ready` are both high at the rising clock edge, and it leaves exactly in a cycle where `out_valid` and `out_ready` are both high.
- R2: `in_ready` equals `out_ready OR NOT out_valid` within the same cycle, so an empty stage or a stage being drained accepts input without a bubble.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change in the next cycle.
- R4: `out_valid` becomes 1 on the edge after an accepted input, and becomes 0 on the edge after a downstream transfer that has no accepted input in the same cycle.
- R5: Words leave in the order they were accepted, each exactly once, under any stall pattern on either side.
- R6: `rst` is synchronous and active high, and after any edge with `rst` high `out_valid` is 0.
- R7: With `CLEAR_DATA` = 1, `out_data` is all zeros after an edge with `rst` high. With `CLEAR_DATA` = 0, reset leaves the data register to its normal load rule.
- R8: With `LOAD_MODE` = `LOAD_ON_ACCEPT` (0), `out_data` changes only on an edge where `in_valid` and `in_ready` were both high, and then it takes that cycle's `in_data`.
- R9: With `LOAD_MODE` = `LOAD_ON_OPEN` (1), `out_data` takes `in_data` on every edge where `in_ready` was high, including cycles where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Stage can take a word this cycle |
| in_data | input | WIDTH | Word from the producer |
| out_valid | output | 1 | Stage holds a word for the consumer |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | WIDTH | Word presented to the consumer |

## Verification
The embedded properties assume that reset is high at the first clock edge and that every input is settled before the rising edge. They do not assume that the producer keeps a word steady once offered: the stage must be correct even when `in_valid` drops without a transfer. The stimulus changes inputs only on the falling edge and keeps `in_valid` low while reset is applied. Two instances receive the same stimulus, one for each pair of data-policy choices, so that both reset behaviours and both load behaviours are compared against a behavioural model.

// File: rtl/elastic_pkg.sv
package elastic_pkg;

    // Data-register load policy
    typedef enum logic {
        LOAD_ON_ACCEPT = 1'b0,   // write only when a word is accepted
        LOAD_ON_OPEN   = 1'b1    // write whenever the stage is ready
    } load_mode_e;

    // Per-cycle transfer events produced by the control path
    typedef struct packed {
        logic take;   // upstream transfer this cycle
        logic give;   // downstream transfer this cycle
        logic open;   // stage ready for input this cycle
    } xfer_t;

    function automatic logic hs_fire(input logic vld, input logic rdy);
        return vld & rdy;
    endfunction

endpackage

// File: rtl/elastic_ctrl.sv
module elastic_ctrl
    import elastic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  out_ready,
    output logic  out_valid,
    output xfer_t xf
);

    logic full_q;

    // Mealy ready: open when empty or when the held word leaves now
    always_comb begin
        xf.open = out_ready | ~full_q;
        xf.take = hs_fire(in_valid, xf.open);
        xf.give = hs_fire(full_q, out_ready);
    end

    always_ff @(posedge clk) begin
        if (rst)
            full_q <= 1'b0;
        else if (xf.take)
            full_q <= 1'b1;
        else if (xf.give)
            full_q <= 1'b0;
    end

    assign out_valid = full_q;

    // R4: an accepted word makes the slot occupied
    p_fill_r4: assert property (@(posedge clk) disable iff (rst)
        xf.take |=> out_valid);

    // R4: draining with nothing arriving empties the slot
    p_drain_r4: assert property (@(posedge clk) disable iff (rst)
        (xf.give && !xf.take) |=> !out_valid);

    // R6: reset empties the slot
    p_rst_empty_r6: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: rtl/elastic_dreg.sv
module elastic_dreg
    import elastic_pkg::*;
#(
    parameter int         WIDTH      = 16,
    parameter bit         CLEAR_DATA = 1'b1,
    parameter load_mode_e LOAD_MODE  = LOAD_ON_ACCEPT
) (
    input  logic             clk,
    input  logic             rst,
    input  xfer_t            xf,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic ld;

    generate
        if (LOAD_MODE == LOAD_ON_ACCEPT) begin : g_gated
            assign ld = xf.take;
        end else begin : g_open
            assign ld = xf.open;
        end
    endgenerate

    generate
        if (CLEAR_DATA) begin : g_clr
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (ld)
                    q <= d;
            end
        end else begin : g_noclr
            always_ff @(posedge clk) begin
                if (ld)
                    q <= d;
            end
        end
    endgenerate

endmodule

// File: rtl/elastic_stage.sv
module elastic_stage
    import elastic_pkg::*;
#(
    parameter int         WIDTH      = 16,
    parameter bit         CLEAR_DATA = 1'b1,
    parameter load_mode_e LOAD_MODE  = LOAD_ON_ACCEPT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    xfer_t xf;

    elastic_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .xf        (xf)
    );

    elastic_dreg #(
        .WIDTH      (WIDTH),
        .CLEAR_DATA (CLEAR_DATA),
        .LOAD_MODE  (LOAD_MODE)
    ) u_dreg (
        .clk (clk),
        .rst (rst),
        .xf  (xf),
        .d   (in_data),
        .q   (out_data)
    );

    assign in_ready = xf.open;

    // R2: an empty stage always reports ready
    p_ready_empty_r2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R3: a stalled word is held unchanged
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R5: an accepted word is what appears next at the output
    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_data == $past(in_data)));

    generate
        if (CLEAR_DATA) begin : g_chk_clr
            // R7: reset clears the data register
            p_data_clear_r7: assert property (@(posedge clk)
                rst |=> (out_data == '0));
        end
        if (LOAD_MODE == LOAD_ON_ACCEPT) begin : g_chk_gated
            // R8: no accepted word, no change
            p_gate_hold_r8: assert property (@(posedge clk) disable iff (rst)
                !(in_valid && in_ready) |=> $stable(out_data));
        end else begin : g_chk_open
            // R9: data follows the input whenever ready
            p_open_load_r9: assert property (@(posedge clk) disable iff (rst)
                in_ready |=> (out_data == $past(in_data)));
        end
    endgenerate

endmodule

// File: tb/sim_elastic_stage.sv
module sim_elastic_stage;
    import elastic_pkg::*;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         out_ready = 1'b0;
    logic [W-1:0] in_data = '0;

    logic         ir0, ov0, ir1, ov1;
    logic [W-1:0] od0, od1;

    always #4 clk = ~clk;   // 125 MHz

    elastic_stage #(.WIDTH(W), .CLEAR_DATA(1'b1), .LOAD_MODE(LOAD_ON_ACCEPT)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir0), .in_data(in_data),
        .out_valid(ov0), .out_ready(out_ready), .out_data(od0));

    elastic_stage #(.WIDTH(W), .CLEAR_DATA(1'b0), .LOAD_MODE(LOAD_ON_OPEN)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir1), .in_data(in_data),
        .out_valid(ov1), .out_ready(out_ready), .out_data(od1));

    int checks = 0;
    int errors = 0;
    int pushes = 0;
    int pops   = 0;
    bit done   = 1'b0;

    // behavioural model state
    logic         m_vld = 1'b0;
    logic [W-1:0] m_d0 = '0;
    logic [W-1:0] m_d1 = '0;
    bit           m1_known = 1'b0;
    bit           prev_rst = 1'b1;
    bit           prev_stall = 1'b0;
    logic [W-1:0] prev_data = '0;
    logic [W-1:0] sb[$];

    always @(posedge clk) begin
        logic open;
        open = out_ready | ~m_vld;
        if (open) begin
            m_d1 = in_data;
            m1_known = 1'b1;
        end
        if (rst) begin
            m_vld = 1'b0;
            m_d0  = '0;
        end else begin
            if (in_valid && open)
                m_d0 = in_data;
            if (in_valid && open)
                m_vld = 1'b1;
            else if (out_ready)
                m_vld = 1'b0;
        end
        prev_rst = rst;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic r, input logic [W-1:0] d, input logic rs);
        @(negedge clk);
        chk(ov0 === m_vld, prev_rst ? "R6" : "R4", "u0 out_valid", W'(ov0), W'(m_vld));
        chk(ov1 === m_vld, prev_rst ? "R6" : "R4", "u1 out_valid", W'(ov1), W'(m_vld));
        chk(od0 === m_d0, prev_rst ? "R7" : "R8", "u0 out_data", od0, m_d0);
        if (m1_known)
            chk(od1 === m_d1, prev_rst ? "R7" : "R9", "u1 out_data", od1, m_d1);
        if (prev_stall && !prev_rst)
            chk(ov0 === 1'b1 && od0 === prev_data, "R3", "stalled word held", od0, prev_data);
        in_valid  = v;
        out_ready = r;
        in_data   = d;
        rst       = rs;
        if (rs) sb.delete();
        #1;
        chk(ir0 === (r | ~m_vld), "R2", "u0 in_ready", W'(ir0), W'(r | ~m_vld));
        chk(ir1 === (r | ~m_vld), "R2", "u1 in_ready", W'(ir1), W'(r | ~m_vld));
        if (!rs) begin
            if (ov0 && r) begin
                if (sb.size() == 0)
                    chk(1'b0, "R5", "output with empty scoreboard", od0, '0);
                else begin
                    chk(od0 === sb[0], "R5", "order", od0, sb[0]);
                    void'(sb.pop_front());
                end
                pops++;
            end
            if (v && ir0) begin
                sb.push_back(d);
                pushes++;
            end
        end
        prev_stall = ov0 && !r && !rs;
        prev_data  = od0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset at time zero
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 16'h00A5, 1'b1);
        // R1 R2: full throughput
        for (int i = 0; i < 40; i++) cycle(1'b1, 1'b1, W'(16'h1000 + i), 1'b0);
        // R3: downstream stalled with offers pending
        for (int i = 0; i < 10; i++) cycle(1'b1, 1'b0, W'(16'h2000 + i), 1'b0);
        // R4: drain with no input
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, W'(16'h3000 + i), 1'b0);
        // R8 R9: idle input with changing data, consumer ready
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, W'(16'h4000 + 7 * i), 1'b0);
        // R5: random stalls on both sides
        for (int i = 0; i < 600; i++)
            cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0),
                  W'($urandom), 1'b0);
        // load a word, stall, then reset mid-stream (R6 R7)
        cycle(1'b1, 1'b1, 16'hBEEF, 1'b0);
        cycle(1'b0, 1'b0, 16'hBEEF, 1'b0);
        cycle(1'b0, 1'b0, 16'h5A5A, 1'b1);
        cycle(1'b0, 1'b0, 16'h5A5A, 1'b1);
        // after reset: more random traffic
        for (int i = 0; i < 300; i++)
            cycle(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                  W'($urandom), 1'b0);
        // final drain
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 16'h0000, 1'b0);
        // R1: every accepted word was delivered
        chk(sb.size() == 0 && pushes > 0, "R1", "words left undelivered",
            W'(sb.size()), '0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule